// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Bit-Centred Clock Output

This block sends and receives asynchronous serial frames. Each frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit and one or two high stop bits. All bit timing comes from a 16x tick. That tick has one of two sources. The first is an internal divider that fires once every `cfg_divisor` system clocks. The second is the rising edges of an external clock input, which runs at sixteen times the bit rate.

When the internal source is in use and the clock output is enabled, `clk_out` runs at the bit rate while a frame is in flight. It is low for the first half of each bit and rises at the centre of the bit. When no frame is in flight it rests high.

Software-side control is a set of plain strobes and levels. `tx_wr` loads the transmit holding register and `rx_rd` acknowledges received data. `tx_en` and `rx_en` enable the two directions. The format fields take a new value only while both enables are low.

Top module: `uart_bitclk`

## Requirements
- R1: The transmitter sends the following bits, in this order, on `txd`. First a start bit of 0. Then `tx_data[0]` through `tx_data[7]`. Then the parity bit, if `cfg_par_en` is 1. Then one stop bit of 1, or two if `cfg_two_stop` is 1. `txd` is 1 whenever no frame is being sent.
- R2: The parity bit makes the number of ones in the data bits plus the parity bit even when `cfg_par_odd` is 0, and odd when `cfg_par_odd` is 1.
- R3: With the internal source, each bit lasts 16*`cfg_divisor` system clocks. With `cfg_ext_clk` set to 1, each bit lasts 16 rising edges of `ext_clk_in`.
- R4: Take the case where `cfg_clk_out_en` is 1 and `cfg_ext_clk` is 0. During a frame, `clk_out` is 0 in the first half of each bit and 1 in the second half. Outside a frame, `clk_out` is 1. When the external source is selected, or the output is disabled, `clk_out` stays at 1.
- R5: The receiver starts on a falling edge of `rxd` and confirms the start bit 8 ticks later. A low pulse shorter than half a bit is therefore ignored. The receiver samples each following bit at its centre. When a frame completes, it loads `rx_data` and sets `rx_full` to 1.
- R6: `par_err` is set to 1 when parity is enabled and the received parity bit does not match the rule in R2.
- R7: `frm_err` is set to 1 when the first stop bit is received as 0.
- R8: If a frame completes while `rx_full` is 1, `ovr_err` is set to 1 and `rx_data` keeps its old value.
- R9: A pulse on `rx_rd` clears `rx_full`, `par_err`, `frm_err` and `ovr_err`.
- R10: `tx_wr` with `tx_en` high clears `tx_empty`. Moving the data into the shifter sets `tx_empty` to 1 again. While `tx_en` is 0, `tx_empty` is 1, any frame is abandoned and `txd` returns to 1.
- R11: While `rx_en` is 0, `rx_full`, `par_err`, `frm_err`, `ovr_err` and `rx_data` keep their values, and incoming frames are ignored.
- R12: A `cfg_wr` pulse updates the format and clock settings only when `tx_en` and `rx_en` are both 0. At any other time the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Strobe that stores the cfg_* values |
| cfg_ext_clk | input | 1 | 1 selects ext_clk_in as the 16x source |
| cfg_clk_out_en | input | 1 | Enables clk_out when the internal source is used |
| cfg_par_en | input | 1 | Adds a parity bit to each frame |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | 1 sends two stop bits |
| cfg_divisor | input | 16 | System clocks per 16x tick (0 is treated as 1) |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Acknowledges received data and clears the receive flags |
| ext_clk_in | input | 1 | External clock at 16x the bit rate |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| clk_out | output | 1 | Bit-rate clock that rises at the centre of each bit |
| rx_data | output | 8 | Last received byte |
| tx_empty | output | 1 | Transmit holding register is empty |
| rx_full | output | 1 | Received data is waiting |
| par_err | output | 1 | Parity error |
| frm_err | output | 1 | Framing error |
| ovr_err | output | 1 | Overrun |

## Verification
- Serial results are due in bit periods, not in cycles. The start bit appears on `txd` one cycle after the data is accepted, and each later bit follows one bit period after the previous one.
- Each frame is also delayed by up to one tick of phase, because the loaded data waits for the free-running divider. The bench therefore samples every bit and both `clk_out` levels a quarter or half of a bit away from any edge. It measures the exact bit length on a bit whose two edges both fall on ticks.
- Receive flags are due at the centre of the first stop bit, plus two cycles of synchronizer delay. The bench reads them one bit period after it finishes driving or capturing the stop bit.
- Flag changes caused by enables, `rx_rd` and `tx_wr` take effect one clock after the strobe. The bench reads them at the following negative edge.

// File: rtl/uart_bc_pkg.sv
package uart_bc_pkg;
  localparam int DW        = 8;
  localparam int DIV_W     = 16;
  localparam int FRAME_MAX = DW + 4;

  typedef struct packed {
    logic             ext;
    logic             clk_out_en;
    logic             par_en;
    logic             par_odd;
    logic             two_stop;
    logic [DIV_W-1:0] divisor;
  } cfg_t;

  // parity bit that makes data+parity even (odd=0) or odd (odd=1)
  function automatic logic par_bit(logic [DW-1:0] d, logic odd);
    return (^d) ^ odd;
  endfunction

  // number of bits in one frame
  function automatic logic [3:0] frame_len(logic par_en, logic two_stop);
    return 4'(DW + 2) + {3'b000, par_en} + {3'b000, two_stop};
  endfunction

  // frame image, bit 0 leaves first; unused upper bits are idle ones
  function automatic logic [FRAME_MAX-1:0] build_frame(logic [DW-1:0] d,
                                                       logic par_en, logic odd);
    logic [FRAME_MAX-1:0] f;
    f        = '1;
    f[0]     = 1'b0;
    f[DW:1]  = d;
    if (par_en) f[DW+1] = par_bit(d, odd);
    return f;
  endfunction
endpackage

// File: rtl/uart_bc_tick.sv
module uart_bc_tick
  import uart_bc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic [DIV_W-1:0] divisor,
  input  logic             ext_clk_in,
  output logic             tick
);
  logic [2:0]       ext_sync;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_m1;
  logic             ext_rise;
  logic             int_tick;

  assign div_m1   = (divisor == '0) ? '0 : divisor - 1'b1;
  assign int_tick = (cnt == div_m1);
  assign ext_rise = ext_sync[1] & ~ext_sync[2];
  assign tick     = ext_sel ? ext_rise : int_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_sync <= '0;
      cnt      <= '0;
    end else begin
      ext_sync <= {ext_sync[1:0], ext_clk_in};
      cnt      <= (cnt >= div_m1) ? '0 : cnt + 1'b1;
    end
  end

  // R3: the internal counter never runs past the programmed limit
  assert_div_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= div_m1) || $changed(div_m1) || $past(cnt > div_m1)
      |=> (cnt <= div_m1) || $changed(div_m1));
endmodule

// File: rtl/uart_bc_tx.sv
module uart_bc_tx
  import uart_bc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          two_stop,
  output logic          txd,
  output logic          tx_empty,
  output logic          busy,
  output logic [3:0]    phase
);
  logic [DW-1:0]        hold;
  logic [FRAME_MAX-1:0] shift;
  logic [3:0]           bits_left;
  logic [3:0]           sub;

  assign txd   = shift[0];
  assign phase = sub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= '0;
      shift     <= '1;
      bits_left <= '0;
      sub       <= '0;
      busy      <= 1'b0;
      tx_empty  <= 1'b1;
    end else if (!tx_en) begin
      tx_empty <= 1'b1;
      busy     <= 1'b0;
      shift    <= '1;
      sub      <= '0;
    end else begin
      if (busy) begin
        if (tick) begin
          sub <= sub + 4'd1;
          if (sub == 4'd15) begin
            shift     <= {1'b1, shift[FRAME_MAX-1:1]};
            bits_left <= bits_left - 4'd1;
            if (bits_left == 4'd1) busy <= 1'b0;
          end
        end
      end else if (!tx_empty) begin
        shift     <= build_frame(hold, par_en, par_odd);
        bits_left <= frame_len(par_en, two_stop);
        sub       <= '0;
        busy      <= 1'b1;
        tx_empty  <= 1'b1;
      end
      if (tx_wr) begin
        hold     <= tx_data;
        tx_empty <= 1'b0;
      end
    end
  end

  assert_txen_low_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tx_empty && txd);
  assert_start_bit_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
endmodule

// File: rtl/uart_bc_rx.sv
module uart_bc_rx
  import uart_bc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_en,
  input  logic          rxd,
  input  logic          rx_rd,
  input  logic          par_en,
  input  logic          par_odd,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          par_err,
  output logic          frm_err,
  output logic          ovr_err,
  output logic          busy,
  output logic [3:0]    phase,
  output logic          done
);
  logic [1:0]    sync;
  logic          rxd_s;
  logic          rx_prev;
  logic [3:0]    sub;
  logic [3:0]    idx;
  logic [3:0]    last_idx;
  logic [DW-1:0] sh;
  logic          pbit;

  assign rxd_s    = sync[1];
  assign phase    = sub;
  assign last_idx = par_en ? 4'(DW + 2) : 4'(DW + 1);
  assign done     = rx_en && tick && busy && (sub == 4'd7) && (idx == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      rx_prev <= 1'b1;
      sub     <= '0;
      idx     <= '0;
      sh      <= '0;
      pbit    <= 1'b0;
      busy    <= 1'b0;
      rx_data <= '0;
      rx_full <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      ovr_err <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      if (rx_rd) begin
        rx_full <= 1'b0;
        par_err <= 1'b0;
        frm_err <= 1'b0;
        ovr_err <= 1'b0;
      end
      if (!rx_en) begin
        busy    <= 1'b0;
        rx_prev <= 1'b1;
      end else if (tick) begin
        rx_prev <= rxd_s;
        if (!busy) begin
          if (rx_prev && !rxd_s) begin
            busy <= 1'b1;
            sub  <= 4'd1;
            idx  <= '0;
          end
        end else begin
          sub <= sub + 4'd1;
          if (sub == 4'd7) begin
            idx <= idx + 4'd1;
            if (idx == 4'd0) begin
              if (rxd_s) busy <= 1'b0;
            end else if (idx <= 4'(DW)) begin
              sh <= {rxd_s, sh[DW-1:1]};
            end else if (idx == last_idx) begin
              busy <= 1'b0;
            end else begin
              pbit <= rxd_s;
            end
          end
        end
      end
      if (done) begin
        if (rx_full && !rx_rd) begin
          ovr_err <= 1'b1;
        end else begin
          rx_data <= sh;
          rx_full <= 1'b1;
          par_err <= par_en && (pbit != par_bit(sh, par_odd));
          frm_err <= !rxd_s;
        end
      end
    end
  end

  assert_rxen_low_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !rx_rd |=> $stable(rx_full) && $stable(rx_data) && $stable(par_err)
                         && $stable(frm_err) && $stable(ovr_err));
  assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && rx_full && !rx_rd |=> ovr_err && $stable(rx_data));
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !done |=> !rx_full && !ovr_err && !par_err && !frm_err);
endmodule

// File: rtl/uart_bitclk.sv
module uart_bitclk
  import uart_bc_pkg::*;
#(
  parameter logic [DIV_W-1:0] RESET_DIV = 16'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_ext_clk,
  input  logic             cfg_clk_out_en,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             tx_wr,
  input  logic [DW-1:0]    tx_data,
  input  logic             rx_rd,
  input  logic             ext_clk_in,
  input  logic             rxd,
  output logic             txd,
  output logic             clk_out,
  output logic [DW-1:0]    rx_data,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             par_err,
  output logic             frm_err,
  output logic             ovr_err
);
  cfg_t       cfg;
  logic       tick;
  logic       tx_busy;
  logic       rx_busy;
  logic       rx_done;
  logic [3:0] tx_phase;
  logic [3:0] rx_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '{ext: 1'b0, clk_out_en: 1'b0, par_en: 1'b0, par_odd: 1'b0,
               two_stop: 1'b0, divisor: RESET_DIV};
    end else if (cfg_wr && !tx_en && !rx_en) begin
      cfg <= '{ext: cfg_ext_clk, clk_out_en: cfg_clk_out_en, par_en: cfg_par_en,
               par_odd: cfg_par_odd, two_stop: cfg_two_stop, divisor: cfg_divisor};
    end
  end

  uart_bc_tick u_tick (
    .clk(clk), .rst_n(rst_n), .ext_sel(cfg.ext), .divisor(cfg.divisor),
    .ext_clk_in(ext_clk_in), .tick(tick)
  );

  uart_bc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .tx_wr(tx_wr),
    .tx_data(tx_data), .par_en(cfg.par_en), .par_odd(cfg.par_odd),
    .two_stop(cfg.two_stop), .txd(txd), .tx_empty(tx_empty), .busy(tx_busy),
    .phase(tx_phase)
  );

  uart_bc_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .rxd(rxd),
    .rx_rd(rx_rd), .par_en(cfg.par_en), .par_odd(cfg.par_odd),
    .rx_data(rx_data), .rx_full(rx_full), .par_err(par_err),
    .frm_err(frm_err), .ovr_err(ovr_err), .busy(rx_busy), .phase(rx_phase),
    .done(rx_done)
  );

  // low in the first half of a bit, rising at the 8th tick (bit centre)
  always_comb begin
    if (!cfg.clk_out_en || cfg.ext) clk_out = 1'b1;
    else if (tx_busy)               clk_out = tx_phase[3];
    else if (rx_busy)               clk_out = rx_phase[3];
    else                            clk_out = 1'b1;
  end

  assert_ext_no_clkout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.ext |-> clk_out);
  assert_cfg_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en || rx_en) |=> $stable(cfg));
endmodule

// File: tb/uart_bitclk_bench.sv
`timescale 1ns/1ps
module uart_bitclk_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 0, c_ext = 0, c_ck = 0, c_par = 0, c_odd = 0, c_two = 0;
  logic [15:0] c_div = 16'd4;
  logic        tx_en = 0, rx_en = 0, tx_wr = 0, rx_rd = 0;
  logic [7:0]  tx_data = 8'h00;
  logic        ext_clk = 1'b0, ext_run = 1'b0;
  logic        loop = 1'b0, rxd_drv = 1'b1;
  wire         rxd;
  logic        txd, clk_out, tx_empty, rx_full, par_err, frm_err, ovr_err;
  logic [7:0]  rx_data;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  localparam int BITC = 64;   // 16 * divisor 4
  localparam int EXTC = 128;  // 16 * 8-cycle external period

  // {par_en, par_odd, two_stop, data}
  localparam logic [10:0] VEC [0:5] = '{
    {3'b000, 8'hA5}, {3'b100, 8'h3C}, {3'b110, 8'h81},
    {3'b001, 8'h00}, {3'b111, 8'hFF}, {3'b101, 8'h5E}
  };

  assign rxd = loop ? txd : rxd_drv;

  always #2.5 clk = ~clk;
  always begin
    #20;
    if (ext_run) ext_clk = ~ext_clk;
  end

  uart_bitclk u_uart_bitclk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ext_clk(c_ext),
    .cfg_clk_out_en(c_ck), .cfg_par_en(c_par), .cfg_par_odd(c_odd),
    .cfg_two_stop(c_two), .cfg_divisor(c_div), .tx_en(tx_en), .rx_en(rx_en),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .ext_clk_in(ext_clk),
    .rxd(rxd), .txd(txd), .clk_out(clk_out), .rx_data(rx_data),
    .tx_empty(tx_empty), .rx_full(rx_full), .par_err(par_err),
    .frm_err(frm_err), .ovr_err(ovr_err)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic e, input logic ck, input logic p, input logic o,
                         input logic t, input logic [15:0] d);
    c_ext = e; c_ck = ck; c_par = p; c_odd = o; c_two = t; c_div = d;
    cfg_wr = 1'b1; wait_cyc(1); cfg_wr = 1'b0; wait_cyc(1);
  endtask

  task automatic send_byte(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1; wait_cyc(1); tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    rx_rd = 1'b1; wait_cyc(1); rx_rd = 1'b0;
  endtask

  task automatic wait_txd(input logic lvl);
    int k = 0;
    while (txd !== lvl && k < 20000) begin wait_cyc(1); k++; end
  endtask

  task automatic capture(input int n, input int bc, output logic [11:0] bits,
                         output logic ck_lo, output logic ck_hi);
    bits = '1;
    wait_txd(1'b0);
    wait_cyc(bc/4); ck_lo = clk_out;
    wait_cyc(bc/4); bits[0] = txd;
    wait_cyc(bc/4); ck_hi = clk_out;
    wait_cyc(bc/4);
    for (int i = 1; i < n; i++) begin
      wait_cyc(bc/2); bits[i] = txd; wait_cyc(bc/2);
    end
  endtask

  task automatic drive_rx(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin rxd_drv = bits[i]; wait_cyc(BITC); end
    rxd_drv = 1'b1; wait_cyc(BITC);
  endtask

  function automatic logic ones_odd(input logic [7:0] d);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(d[i]);
    return (c % 2) == 1;
  endfunction

  // high-time of data bit 0 for byte 0x01: exactly one bit period
  task automatic measure_bit(output int w);
    w = 0;
    wait_txd(1'b0);
    wait_txd(1'b1);
    while (txd === 1'b1 && w < 1000) begin w++; wait_cyc(1); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] bits;
    logic        lo, hi;
    int          w;
    wait_cyc(4); rst_n = 1'b1; wait_cyc(2);

    // reset state
    check("R10 reset tx_empty", tx_empty, 1);
    check("R9 reset rx_full", rx_full, 0);
    check("R1 reset txd idle", txd, 1);
    check("R4 reset clk_out", clk_out, 1);
    check("R9 reset errors", {par_err, frm_err, ovr_err}, 0);

    // vector table: loopback frames
    loop = 1'b1;
    for (int v = 0; v < 6; v++) begin
      logic [7:0]  d;
      logic        p, o, t, pb;
      logic [11:0] exp;
      int          n;
      {p, o, t, d} = VEC[v];
      tx_en = 0; rx_en = 0; wait_cyc(1);
      set_cfg(1'b0, 1'b1, p, o, t, 16'd4);
      tx_en = 1; rx_en = 1; wait_cyc(2);
      send_byte(d);
      n = 10 + int'(p) + int'(t);
      pb = o ? !ones_odd(d) : ones_odd(d);
      exp = '1; exp[0] = 1'b0; exp[8:1] = d;
      if (p) exp[9] = pb;
      capture(n, BITC, bits, lo, hi);
      check("R1 frame bits", bits, exp);
      if (p) check("R2 parity bit", bits[9], pb);
      check("R4 clk_out low first half", lo, 0);
      check("R4 clk_out high second half", hi, 1);
      wait_cyc(BITC);
      check("R5 loopback data", rx_data, d);
      check("R5 loopback full", rx_full, 1);
      check("R6 loopback parity ok", par_err, 0);
      check("R7 loopback stop ok", frm_err, 0);
      check("R10 tx_empty after frame", tx_empty, 1);
      read_rx();
      check("R9 read clears full", rx_full, 0);
    end

    // R3 internal bit length
    tx_en = 0; rx_en = 0; wait_cyc(1);
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd4);
    tx_en = 1; wait_cyc(2);
    send_byte(8'h01);
    measure_bit(w);
    check("R3 internal bit length", w, BITC);
    wait_cyc(12 * BITC);

    // R12: format write while enabled is ignored (0x03 even parity would be 0)
    set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd4);
    send_byte(8'h03);
    capture(11, BITC, bits, lo, hi);
    check("R12 format write ignored", bits[9], 1);
    wait_cyc(2 * BITC);

    // R10: pending data then tx_en low
    send_byte(8'h55);
    wait_txd(1'b0);
    send_byte(8'h66);
    check("R10 write clears tx_empty", tx_empty, 0);
    tx_en = 0; wait_cyc(2);
    check("R10 tx_en low sets tx_empty", tx_empty, 1);
    check("R10 tx_en low idles txd", txd, 1);

    // directed receive tests, parity on, even
    loop = 1'b0;
    set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd4);
    rx_en = 1; wait_cyc(4 * BITC);
    drive_rx({1'b1, 1'b1, 1'b0, 8'h01, 1'b0}, 11);   // parity should be 1
    check("R6 parity error set", par_err, 1);
    check("R5 data with bad parity", rx_data, 8'h01);
    check("R7 no framing error", frm_err, 0);
    read_rx();
    check("R9 read clears parity error", par_err, 0);

    drive_rx({1'b1, 1'b0, 1'b1, 8'h10, 1'b0}, 11);   // stop bit low
    check("R7 framing error set", frm_err, 1);
    read_rx();
    check("R9 read clears framing error", frm_err, 0);

    drive_rx({1'b1, 1'b1, 1'b0, 8'h11, 1'b0}, 11);
    drive_rx({1'b1, 1'b1, 1'b0, 8'h22, 1'b0}, 11);
    check("R8 overrun flag", ovr_err, 1);
    check("R8 old data kept", rx_data, 8'h11);

    rx_en = 0; wait_cyc(2);
    drive_rx({1'b1, 1'b1, 1'b0, 8'h33, 1'b0}, 11);
    check("R11 data kept", rx_data, 8'h11);
    check("R11 full kept", rx_full, 1);
    check("R11 overrun kept", ovr_err, 1);
    read_rx();
    check("R9 read clears overrun", ovr_err, 0);

    rx_en = 1; wait_cyc(BITC);
    rxd_drv = 1'b0; wait_cyc(20); rxd_drv = 1'b1;
    wait_cyc(3 * BITC);
    check("R5 short glitch ignored", rx_full, 0);

    // external clock source
    rx_en = 0; tx_en = 0; wait_cyc(1);
    set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd4);
    ext_run = 1'b1; wait_cyc(40);
    tx_en = 1; wait_cyc(2);
    send_byte(8'h01);
    wait_txd(1'b0);
    wait_cyc(EXTC/2);
    check("R4 clk_out held with ext source", clk_out, 1);
    measure_bit(w);
    check("R3 external bit length", w, EXTC);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule